// File: doc/BRIEF.md
# Cache Maintenance Operation Engine

This block runs maintenance commands against the tag store of a write-back, set-associative cache. It holds the tag, valid and dirty bits for every way as internal registers. It takes one command at a time. Each command carries an operation code and a 32-bit argument, which is either an address or a set index. The engine walks the affected ways and reads their state. Where a line has to reach memory, it raises a write-back request on a request/acknowledge port and waits for the acknowledge before changing that way's bits.

The operations are flush, invalidate and combined flush-and-invalidate, each by address or by set, plus flush of the whole cache and invalidate of the whole cache. The combined operation is atomic and only touches lines that are both valid and dirty. A clean line stays valid, so it can be issued without first checking whether the line holds modified data. Set-level and whole-cache flushes never write back an invalid way, even when a stale dirty bit was left behind by a plain invalidate.

For test and bring-up, a fill port writes the tag, valid and dirty bits of one way, and a probe port reads them back combinationally.

Top module: `cache_maint_engine`

## Requirements
- R1: After reset, busy, done and wb_req are low and every way reads back invalid and clean on the probe port.
- R2: Flush by address (op 0): an address splits into offset (low OFF_W bits), set (next SET_W bits) and tag (the rest). If the tag matches a valid way of that set and the way is dirty, one write-back is issued and only the dirty bit is cleared. A miss or a clean hit issues nothing and changes nothing.
- R3: Invalidate by address (op 1): on a valid tag match, the valid bit is cleared with no write-back. The dirty bit is left as it was.
- R4: Flush-and-invalidate by address (op 2): a valid dirty hit is written back, then its valid and dirty bits are both cleared. A clean hit or a miss is a no-op, and a clean line stays valid.
- R5: Flush by set (op 3, set index in the argument): every way of the set that is valid and dirty is written back and its dirty bit cleared. Invalid ways are never written, whatever their dirty bit.
- R6: Flush-and-invalidate by set (op 5): each valid dirty way is written back and then made invalid and clean. Clean or invalid ways are unchanged.
- R7: Invalidate by set (op 4): every way of the set becomes invalid without any write-back, and dirty bits are left as they were.
- R8: A set command (ops 3, 4, 5) whose argument is not below SETS changes no state and issues no write-back. Its done pulse is seen in the first cycle after the accepting edge.
- R9: Flush-all (op 6) writes back every valid dirty line, in ascending set order and ascending way order within a set, clearing its dirty bit. Invalidate-all (op 7) clears every valid bit with no write-back.
- R10: A write-back presents the address {tag, set, zero offset} and the way number. wb_req and both fields stay stable until wb_ack is sampled high, and only one write-back is outstanding at a time.
- R11: A command is accepted when cmd_valid is high and busy is low. Busy rises in the next cycle and stays high through the one-cycle done pulse. A command presented while busy is ignored.
- R12: Timing: each visited way costs one cycle and each write-back costs one extra cycle beyond the cycles spent waiting for wb_ack. An address or set command visits WAYS ways, and an all-cache command visits SETS*WAYS ways.
- R13: When the engine is idle, a fill with fill_en high writes the tag, valid and dirty of the selected way, and the probe port returns them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Operation code (0..7, see requirements) |
| cmd_arg | input | ADDR_W | Address or set index |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | ADDR_W | Line address of the write-back |
| wb_way | output | WAY_W | Way being written back |
| wb_ack | input | 1 | Write-back accepted |
| fill_en | input | 1 | Test fill strobe |
| fill_set | input | SET_W | Fill set |
| fill_way | input | WAY_W | Fill way |
| fill_tag | input | TAG_W | Fill tag |
| fill_valid | input | 1 | Fill valid bit |
| fill_dirty | input | 1 | Fill dirty bit |
| probe_set | input | SET_W | Probe set |
| probe_way | input | WAY_W | Probe way |
| probe_tag | output | TAG_W | Probed tag |
| probe_valid | output | 1 | Probed valid bit |
| probe_dirty | output | 1 | Probed dirty bit |

## Verification
A command's done pulse is due in a sample cycle fixed by the visited way count plus (ack wait + 1) per write-back. The bench computes that count from its own model and compares it with the sample on which done is first seen, with one cycle for an ignored set index. Each write-back is compared against the head of the model's expected queue in the cycle where the bench raises wb_ack, so both the order and the address are checked at the moment of hand-off. The final tag state is read back through the probe port once done has been seen and the engine is idle, when no further update can be pending.

// File: rtl/cache_maint_engine.sv
module cache_maint_engine #(
  parameter int SETS       = 8,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 16,
  parameter int ADDR_W     = 32,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int TAG_W = ADDR_W - SET_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_arg,
  output logic              busy,
  output logic              done,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [WAY_W-1:0]  wb_way,
  input  logic              wb_ack,
  input  logic              fill_en,
  input  logic [SET_W-1:0]  fill_set,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic              fill_valid,
  input  logic              fill_dirty,
  input  logic [SET_W-1:0]  probe_set,
  input  logic [WAY_W-1:0]  probe_way,
  output logic [TAG_W-1:0]  probe_tag,
  output logic              probe_valid,
  output logic              probe_dirty
);
  localparam int LINES = SETS * WAYS;
  localparam int IDX_W = SET_W + WAY_W;

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_WB, S_FIN} state_t;

  state_t            st;
  logic [2:0]        op_q;
  logic [SET_W-1:0]  set_q;
  logic [WAY_W-1:0]  way_q;
  logic [TAG_W-1:0]  key_q;

  logic [TAG_W-1:0]  tags [LINES];
  logic [LINES-1:0]  vld, drt;

  logic [IDX_W-1:0]  cur, fidx, pidx;
  assign cur  = {set_q, way_q};
  assign fidx = {fill_set, fill_way};
  assign pidx = {probe_set, probe_way};

  logic by_addr, whole, combo, flushy, inv_only;
  assign by_addr  = op_q <= 3'd2;
  assign whole    = op_q >= 3'd6;
  assign combo    = (op_q == 3'd2) || (op_q == 3'd5);
  assign inv_only = (op_q == 3'd1) || (op_q == 3'd4) || (op_q == 3'd7);
  assign flushy   = !inv_only;

  logic sel, need_wb, last_way, last, step, clr_v, clr_d, accept, bad_idx;
  assign sel      = vld[cur] && (!by_addr || tags[cur] == key_q);
  assign need_wb  = sel && drt[cur] && flushy;
  assign last_way = way_q == WAY_W'(WAYS - 1);
  assign last     = last_way && (!whole || set_q == SET_W'(SETS - 1));
  assign step     = (st == S_SCAN && !need_wb) || (st == S_WB && wb_ack);
  assign clr_v    = (st == S_SCAN && sel && inv_only) || (st == S_WB && wb_ack && combo);
  assign clr_d    = st == S_WB && wb_ack;
  assign accept   = cmd_valid && st == S_IDLE;
  assign bad_idx  = (cmd_op >= 3'd3) && (cmd_op <= 3'd5) && (cmd_arg >= ADDR_W'(SETS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      op_q  <= '0;
      set_q <= '0;
      way_q <= '0;
      key_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          op_q  <= cmd_op;
          way_q <= '0;
          key_q <= cmd_arg[ADDR_W-1 -: TAG_W];
          if (cmd_op <= 3'd2)      set_q <= cmd_arg[OFF_W +: SET_W];
          else if (cmd_op <= 3'd5) set_q <= cmd_arg[SET_W-1:0];
          else                     set_q <= '0;
          st <= bad_idx ? S_FIN : S_SCAN;
        end
        S_SCAN, S_WB: begin
          if (st == S_SCAN && need_wb) st <= S_WB;
          else if (step) begin
            if (last) st <= S_FIN;
            else begin
              st    <= S_SCAN;
              way_q <= way_q + 1'b1;
              if (last_way) set_q <= set_q + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      drt <= '0;
    end else if (fill_en && st == S_IDLE) begin
      vld[fidx] <= fill_valid;
      drt[fidx] <= fill_dirty;
    end else begin
      if (clr_v) vld[cur] <= 1'b0;
      if (clr_d) drt[cur] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && st == S_IDLE) tags[fidx] <= fill_tag;
  end

  assign busy        = st != S_IDLE;
  assign done        = st == S_FIN;
  assign wb_req      = st == S_WB;
  assign wb_addr     = {tags[cur], set_q, {OFF_W{1'b0}}};
  assign wb_way      = way_q;
  assign probe_tag   = tags[pidx];
  assign probe_valid = vld[pidx];
  assign probe_dirty = drt[pidx];
endmodule

module cache_maint_engine_chk #(
  parameter int SETS   = 8,
  parameter int ADDR_W = 32,
  parameter int WAY_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_arg,
  input logic              busy,
  input logic              done,
  input logic              wb_req,
  input logic [ADDR_W-1:0] wb_addr,
  input logic [WAY_W-1:0]  wb_way,
  input logic              wb_ack
);
  p_wb_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req && $stable(wb_addr) && $stable(wb_way));

  p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy |=> busy);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  p_done_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy && !wb_req);

  p_idle_no_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wb_req);

  p_bad_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && cmd_op >= 3'd3 && cmd_op <= 3'd5 && cmd_arg >= ADDR_W'(SETS)
    |=> done);
endmodule

bind cache_maint_engine cache_maint_engine_chk #(
  .SETS(SETS), .ADDR_W(ADDR_W), .WAY_W(WAY_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_arg(cmd_arg), .busy(busy), .done(done), .wb_req(wb_req),
  .wb_addr(wb_addr), .wb_way(wb_way), .wb_ack(wb_ack)
);

// File: tb/cache_maint_engine_tb_top.sv
module cache_maint_engine_tb_top;
  localparam int SETS = 8, WAYS = 4, LINE_BYTES = 16, ADDR_W = 32;
  localparam int SET_W = $clog2(SETS), WAY_W = $clog2(WAYS), OFF_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - SET_W - OFF_W;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0; logic [2:0] cmd_op = 0; logic [ADDR_W-1:0] cmd_arg = 0;
  logic busy, done, wb_req, wb_ack;
  logic [ADDR_W-1:0] wb_addr; logic [WAY_W-1:0] wb_way;
  logic fill_en = 0, fill_valid = 0, fill_dirty = 0;
  logic [SET_W-1:0] fill_set = 0, probe_set = 0;
  logic [WAY_W-1:0] fill_way = 0, probe_way = 0;
  logic [TAG_W-1:0] fill_tag = 0, probe_tag;
  logic probe_valid, probe_dirty;

  always #10 clk = ~clk;

  cache_maint_engine #(.SETS(SETS), .WAYS(WAYS), .LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .busy(busy), .done(done), .wb_req(wb_req), .wb_addr(wb_addr), .wb_way(wb_way),
    .wb_ack(wb_ack), .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
    .fill_tag(fill_tag), .fill_valid(fill_valid), .fill_dirty(fill_dirty),
    .probe_set(probe_set), .probe_way(probe_way), .probe_tag(probe_tag),
    .probe_valid(probe_valid), .probe_dirty(probe_dirty));

  int tests = 0, fails = 0;
  int rt [SETS][WAYS];
  bit rv [SETS][WAYS];
  bit rd [SETS][WAYS];
  int exp_addr[$];
  int exp_way[$];
  int ack_delay = 0, ack_cnt = 0;
  string cur_req = "R10";

  function automatic int line_addr(int t, int s);
    return (t << (OFF_W + SET_W)) | (s << OFF_W);
  endfunction

  initial begin
    wb_ack = 0;
    forever begin
      @(negedge clk);
      if (wb_req && !wb_ack) begin
        if (ack_cnt >= ack_delay) begin
          wb_ack = 1; ack_cnt = 0;
          tests++;
          if (exp_addr.size() == 0) begin
            fails++;
            $display("FAIL %s: unexpected write-back addr %h way %0d, expected none", cur_req, wb_addr, wb_way);
          end else begin
            int ea, ew;
            ea = exp_addr.pop_front(); ew = exp_way.pop_front();
            if (wb_addr != ADDR_W'(ea) || int'(wb_way) != ew) begin
              fails++;
              $display("FAIL %s: write-back addr %h way %0d, expected addr %h way %0d", cur_req, wb_addr, wb_way, ea, ew);
            end
          end
        end else ack_cnt++;
      end else wb_ack = 0;
    end
  end

  task automatic fill(int s, int w, int t, bit v, bit d);
    @(negedge clk);
    fill_en = 1; fill_set = SET_W'(s); fill_way = WAY_W'(w); fill_tag = TAG_W'(t);
    fill_valid = v; fill_dirty = d;
    rt[s][w] = t; rv[s][w] = v; rd[s][w] = d;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic check_state(string req);
    int bad = 0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        probe_set = SET_W'(s); probe_way = WAY_W'(w);
        #1;
        if (probe_valid != rv[s][w] || probe_dirty != rd[s][w] ||
            (rv[s][w] && probe_tag != TAG_W'(rt[s][w]))) begin
          if (bad == 0)
            $display("FAIL %s: set %0d way %0d tag %h v%0d d%0d, expected tag %h v%0d d%0d", req, s, w,
                     probe_tag, probe_valid, probe_dirty, rt[s][w], rv[s][w], rd[s][w]);
          bad++;
        end
      end
    tests++;
    if (bad != 0) fails++;
  endtask

  task automatic model(int op, int unsigned arg, int d, output int e);
    int s0, s1, t;
    bit by_addr, combo, inv_only;
    e = 0; t = 0;
    by_addr = op <= 2; combo = op == 2 || op == 5; inv_only = op == 1 || op == 4 || op == 7;
    if (op >= 3 && op <= 5 && arg >= SETS) return;
    if (by_addr) begin
      s0 = int'((arg >> OFF_W) % SETS); s1 = s0; t = int'(arg >> (OFF_W + SET_W));
    end else if (op <= 5) begin
      s0 = int'(arg); s1 = s0;
    end else begin
      s0 = 0; s1 = SETS - 1;
    end
    for (int s = s0; s <= s1; s++)
      for (int w = 0; w < WAYS; w++) begin
        bit sel;
        e++;
        sel = rv[s][w] && (!by_addr || rt[s][w] == t);
        if (sel && rd[s][w] && !inv_only) begin
          exp_addr.push_back(line_addr(rt[s][w], s)); exp_way.push_back(w);
          e += d + 1;
          rd[s][w] = 0;
          if (combo) rv[s][w] = 0;
        end else if (sel && inv_only) rv[s][w] = 0;
      end
  endtask

  task automatic run_cmd(int op, int unsigned arg, int d, string req, bit poke = 0);
    int e, n;
    cur_req = req;
    ack_delay = d;
    model(op, arg, d, e);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'(op); cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 0;
    n = 1;
    while (!done && n < 4000) begin
      @(negedge clk);
      n++;
      if (poke && n == 3) begin cmd_valid = 1; cmd_op = 3'd7; cmd_arg = 0; end
      else cmd_valid = 0;
    end
    tests++;
    if (n != e + 1) begin
      fails++;
      $display("FAIL %s: done seen at sample %0d, expected %0d (op %0d)", req, n, e + 1, op);
    end
    tests++;
    if (exp_addr.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d write-backs missing, expected 0", req, exp_addr.size());
      exp_addr.delete(); exp_way.delete();
    end
    @(negedge clk);
    check_state(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin rt[s][w] = 0; rv[s][w] = 0; rd[s][w] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tests++;
    if (busy || done || wb_req) begin
      fails++;
      $display("FAIL R1: busy %0d done %0d wb_req %0d, expected 0 0 0", busy, done, wb_req);
    end
    check_state("R1");

    fill(2, 0, 'h11, 1, 1); fill(2, 1, 'h22, 1, 0); fill(2, 2, 'h33, 0, 1); fill(2, 3, 'h44, 1, 1);
    fill(5, 0, 'h55, 1, 1); fill(5, 1, 'h66, 1, 1); fill(5, 2, 'h77, 1, 0); fill(5, 3, 'h88, 0, 0);
    fill(7, 1, 'h99, 1, 1);
    check_state("R13");

    run_cmd(0, line_addr('h11, 2) | 5, 0, "R2");
    run_cmd(0, line_addr('h22, 2), 1, "R2");
    run_cmd(0, line_addr('h123, 2), 0, "R2");
    run_cmd(2, line_addr('h22, 2), 0, "R4");
    run_cmd(2, line_addr('h44, 2), 2, "R4");
    run_cmd(1, line_addr('h11, 2), 0, "R3");
    run_cmd(1, line_addr('h99, 7), 0, "R3");

    fill(2, 0, 'h11, 1, 1);
    run_cmd(3, 2, 1, "R5");
    run_cmd(3, SETS, 0, "R8");
    run_cmd(5, SETS + 1, 0, "R8");
    run_cmd(4, 100, 0, "R8");
    run_cmd(5, 5, 1, "R6");

    fill(0, 3, 'h1, 1, 1); fill(2, 1, 'h22, 1, 1); fill(6, 0, 'h2, 1, 1);
    run_cmd(6, 0, 0, "R9", 1);
    fill(5, 0, 'h5A, 1, 1);
    run_cmd(4, 5, 0, "R7");
    fill(1, 1, 'h3, 1, 1);
    run_cmd(6, 0, 3, "R12");
    run_cmd(7, 0, 0, "R9");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule